// File: doc/BRIEF.md
# Dual-Clock Watchdog Timer with Unlock Feed

The block is a watchdog timer with its registers on a bus clock and its counting logic on an independent watchdog clock. Software programs a reload constant and a mode word. It then starts or refreshes the timer by writing a two-word unlock pattern to the feed address. A fixed divide-by-4 prescaler steps a 24-bit down-counter. When the counter passes zero, the block sets a sticky time-out flag. It then either raises an interrupt and keeps running, or raises a held reset request.

Configuration reaches the counting domain through a toggle handshake with a fixed latency. The running count comes back to the bus side as a snapshot that is captured and then handed across. The reset request is produced in the watchdog clock domain. The interrupt and the flags live in the bus clock domain.

Top module: `wdt_dual_clock`

## Requirements
- R1: The counter decrements exactly once every 4 watchdog clock cycles while the timer is running.
- R2: With an effective reload value E, the first underflow (rising `rst_req_o` in reset mode) happens on watchdog clock edge 3 + 4*(E+1), counting the first watchdog edge after the bus edge that accepts the closing feed word as edge 1.
- R3: A reload value below 0xFF is used as 0xFF when the counter is loaded. The RELOAD register (address 1, bits 23:0) still reads back the raw written value.
- R4: A valid feed is a write of 0x0000_00AA to FEED (address 2), then a write of 0x0000_0055 to FEED with no bus access between them (idle cycles are allowed). It reloads the counter and starts counting only if the enable bit is set. With the enable bit clear it has no effect.
- R5: Any other access after the 0xAA word abandons the sequence, and no reload happens. This covers a read, a write to another address, or another FEED value. A new 0xAA word restarts the sequence.
- R6: In reset mode (MODE bit 1 set), an underflow sets `rst_req_o`, which stays high until reset, and sets the time-out flag (MODE bit 2).
- R7: In interrupt mode (MODE bit 1 clear), an underflow sets the interrupt flag (MODE bit 3) and `irq_o`. The counter reloads and keeps running without a feed, and `rst_req_o` stays low.
- R8: The enable bit (MODE bit 0) and the reset-mode bit (MODE bit 1) can be set by a MODE write but not cleared, until reset.
- R9: Writing 1 to MODE bit 2 or bit 3 clears that flag. The time-out flag survives `rst_i` and is cleared only by `por_i`.
- R10: RELOAD and MODE writes reach the counting domain 3 watchdog clock cycles after the bus write. A reload written just before a feed is the value that feed loads.
- R11: VALUE (address 3, bits 23:0) returns a recent snapshot of the counter. It reads 0 while the timer is idle and decreases as the counter runs.
- R12: After reset, MODE reads 0 except for a retained time-out flag, RELOAD reads 0xFF, VALUE reads 0, and `irq_o` and `rst_req_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk_i | input | 1 | Bus clock |
| wclk_i | input | 1 | Watchdog counting clock |
| rst_i | input | 1 | Synchronous active-high system reset; keeps the time-out flag |
| por_i | input | 1 | Synchronous active-high power-on reset; clears everything |
| addr_i | input | 2 | Register address: 0 MODE, 1 RELOAD, 2 FEED, 3 VALUE |
| wr_en_i | input | 1 | Write strobe, one bus cycle per access |
| rd_en_i | input | 1 | Read strobe, one bus cycle per access |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for the addressed register |
| irq_o | output | 1 | Interrupt, high while the interrupt flag is set |
| rst_req_o | output | 1 | Reset request, held high after an underflow in reset mode |

## Verification
A feed takes effect on the third watchdog edge after the bus edge that takes the 0x55 word. The underflow then follows exactly 4*(E+1) edges later. The bench counts watchdog edges from the bus write edge and compares the count to that sum; the two clocks never share an edge. Flags and the interrupt reach the bus side a few bus cycles after the underflow, so the bench waits ten bus cycles before it reads or resets. Snapshots carry a handshake delay of a few cycles, so VALUE is checked against a window computed from the elapsed time.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int CNT_W  = 24;
    localparam int DATA_W = 32;
    localparam int PRE_W  = 2;

    localparam logic [PRE_W-1:0]  PRE_LAST  = '1;
    localparam logic [CNT_W-1:0]  MIN_LOAD  = 24'h0000FF;
    localparam logic [DATA_W-1:0] KEY_OPEN  = 32'h0000_00AA;
    localparam logic [DATA_W-1:0] KEY_CLOSE = 32'h0000_0055;

    typedef enum logic [1:0] {
        A_MODE   = 2'd0,
        A_RELOAD = 2'd1,
        A_FEED   = 2'd2,
        A_VALUE  = 2'd3
    } wdt_addr_e;

    typedef enum logic {
        F_IDLE,
        F_ARMED
    } feed_state_e;

    typedef struct packed {
        logic intf;
        logic tof;
        logic rst_en;
        logic en;
    } wdt_mode_t;

    typedef struct packed {
        logic [CNT_W-1:0] reload;
        logic             rst_en;
    } wdt_cfg_t;

    function automatic logic [CNT_W-1:0] clamp_load(input logic [CNT_W-1:0] v);
        return (v < MIN_LOAD) ? MIN_LOAD : v;
    endfunction

endpackage

// File: rtl/wdt_bit_sync.sv
module wdt_bit_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk_i) begin
        if (rst_i) chain <= '0;
        else       chain <= {chain[STAGES-2:0], d_i};
    end

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/wdt_count_core.sv
module wdt_count_core
    import wdt_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             wclk_i,
    input  logic             rst_i,
    input  logic             cfg_tgl_i,
    input  wdt_cfg_t         cfg_i,
    input  logic             feed_tgl_i,
    input  logic             snap_ack_i,
    output logic             to_tgl_o,
    output logic             snap_tgl_o,
    output logic [CNT_W-1:0] snap_val_o,
    output logic             rst_req_o
);
    logic cfg_s, cfg_d, feed_s, feed_d, ack_s;
    logic cfg_evt, feed_evt, tick, uflow;
    wdt_cfg_t cfg_w, cfg_eff;
    logic running;
    logic [PRE_W-1:0] pre;
    logic [CNT_W-1:0] cnt;

    wdt_bit_sync #(.STAGES(SYNC_STAGES)) u_cfg_sync (
        .clk_i(wclk_i), .rst_i(rst_i), .d_i(cfg_tgl_i), .q_o(cfg_s));
    wdt_bit_sync #(.STAGES(SYNC_STAGES)) u_feed_sync (
        .clk_i(wclk_i), .rst_i(rst_i), .d_i(feed_tgl_i), .q_o(feed_s));
    wdt_bit_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk_i(wclk_i), .rst_i(rst_i), .d_i(snap_ack_i), .q_o(ack_s));

    assign cfg_evt  = cfg_s ^ cfg_d;
    assign feed_evt = feed_s ^ feed_d;
    assign cfg_eff  = cfg_evt ? cfg_i : cfg_w;
    assign tick     = running && !feed_evt && (pre == PRE_LAST);
    assign uflow    = tick && (cnt == '0);

    always_ff @(posedge wclk_i) begin
        if (rst_i) begin
            cfg_d     <= 1'b0;
            feed_d    <= 1'b0;
            cfg_w     <= '{reload: MIN_LOAD, rst_en: 1'b0};
            running   <= 1'b0;
            pre       <= '0;
            cnt       <= '0;
            to_tgl_o  <= 1'b0;
            rst_req_o <= 1'b0;
        end else begin
            cfg_d  <= cfg_s;
            feed_d <= feed_s;
            if (cfg_evt) cfg_w <= cfg_i;
            if (feed_evt) begin
                running <= 1'b1;
                pre     <= '0;
                cnt     <= clamp_load(cfg_eff.reload);
            end else if (running) begin
                pre <= pre + 1'b1;
                if (uflow) begin
                    cnt      <= clamp_load(cfg_eff.reload);
                    to_tgl_o <= ~to_tgl_o;
                    if (cfg_eff.rst_en) rst_req_o <= 1'b1;
                end else if (tick) begin
                    cnt <= cnt - 1'b1;
                end
            end
        end
    end

    // Snapshot: a new capture only once the bus side has acknowledged the last one
    always_ff @(posedge wclk_i) begin
        if (rst_i) begin
            snap_val_o <= '0;
            snap_tgl_o <= 1'b0;
        end else if (snap_tgl_o == ack_s) begin
            snap_val_o <= cnt;
            snap_tgl_o <= ~snap_tgl_o;
        end
    end

    AST_LOAD_CLAMPED: assert property (@(posedge wclk_i) disable iff (rst_i)
        feed_evt |=> (cnt >= MIN_LOAD)); // R3

    AST_STEP_ON_PRESCALE: assert property (@(posedge wclk_i) disable iff (rst_i)
        (running && $past(running) && !$past(feed_evt) && (cnt != $past(cnt)))
        |-> ($past(pre) == PRE_LAST)); // R1

    AST_DOWN_BY_ONE: assert property (@(posedge wclk_i) disable iff (rst_i)
        ($past(running) && !$past(feed_evt) && ($past(pre) == PRE_LAST) && ($past(cnt) != '0))
        |-> (cnt == $past(cnt) - 24'd1)); // R2

    AST_RSTREQ_HELD: assert property (@(posedge wclk_i) disable iff (rst_i)
        rst_req_o |=> rst_req_o); // R6
endmodule

// File: rtl/wdt_bus_regs.sv
module wdt_bus_regs
    import wdt_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              pclk_i,
    input  logic              rst_i,
    input  logic              por_i,
    input  logic [1:0]        addr_i,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              irq_o,
    output wdt_cfg_t          cfg_o,
    output logic              cfg_tgl_o,
    output logic              feed_tgl_o,
    input  logic              to_tgl_i,
    input  logic              snap_tgl_i,
    input  logic [CNT_W-1:0]  snap_val_i,
    output logic              snap_ack_o
);
    localparam int MODE_W = $bits(wdt_mode_t);

    wdt_addr_e   addr;
    feed_state_e fstate;
    logic any_rst;
    logic wr_mode, wr_reload, wr_feed, feed_open, feed_close;
    logic en_q, rsten_q, intf_q, tof_q;
    logic [CNT_W-1:0] reload_q, value_q;
    logic to_s, to_d, to_evt, snap_s, snap_d, snap_evt;
    wdt_mode_t mode_rd;

    assign addr       = wdt_addr_e'(addr_i);
    assign any_rst    = rst_i || por_i;
    assign wr_mode    = wr_en_i && (addr == A_MODE);
    assign wr_reload  = wr_en_i && (addr == A_RELOAD);
    assign wr_feed    = wr_en_i && (addr == A_FEED);
    assign feed_open  = wr_feed && (wdata_i == KEY_OPEN);
    assign feed_close = wr_feed && (wdata_i == KEY_CLOSE) && (fstate == F_ARMED);

    wdt_bit_sync #(.STAGES(SYNC_STAGES)) u_to_sync (
        .clk_i(pclk_i), .rst_i(any_rst), .d_i(to_tgl_i), .q_o(to_s));
    wdt_bit_sync #(.STAGES(SYNC_STAGES)) u_snap_sync (
        .clk_i(pclk_i), .rst_i(any_rst), .d_i(snap_tgl_i), .q_o(snap_s));

    assign to_evt   = to_s ^ to_d;
    assign snap_evt = snap_s ^ snap_d;

    always_ff @(posedge pclk_i) begin
        if (any_rst) begin
            fstate     <= F_IDLE;
            en_q       <= 1'b0;
            rsten_q    <= 1'b0;
            intf_q     <= 1'b0;
            reload_q   <= MIN_LOAD;
            cfg_tgl_o  <= 1'b0;
            feed_tgl_o <= 1'b0;
            to_d       <= 1'b0;
            snap_d     <= 1'b0;
            value_q    <= '0;
            snap_ack_o <= 1'b0;
        end else begin
            to_d   <= to_s;
            snap_d <= snap_s;
            if (wr_en_i || rd_en_i) fstate <= feed_open ? F_ARMED : F_IDLE;
            if (feed_close && en_q) feed_tgl_o <= ~feed_tgl_o;
            if (wr_mode) begin
                en_q      <= en_q | wdata_i[0];
                rsten_q   <= rsten_q | wdata_i[1];
                cfg_tgl_o <= ~cfg_tgl_o;
            end
            if (wr_reload) begin
                reload_q  <= wdata_i[CNT_W-1:0];
                cfg_tgl_o <= ~cfg_tgl_o;
            end
            if (to_evt && !rsten_q)        intf_q <= 1'b1;
            else if (wr_mode && wdata_i[3]) intf_q <= 1'b0;
            if (snap_evt) begin
                value_q    <= snap_val_i;
                snap_ack_o <= snap_s;
            end
        end
    end

    // Time-out flag: only the power-on reset clears it
    always_ff @(posedge pclk_i) begin
        if (por_i)                     tof_q <= 1'b0;
        else if (to_evt)               tof_q <= 1'b1;
        else if (wr_mode && wdata_i[2]) tof_q <= 1'b0;
    end

    assign cfg_o.reload = reload_q;
    assign cfg_o.rst_en = rsten_q;
    assign irq_o        = intf_q;
    assign mode_rd      = '{intf: intf_q, tof: tof_q, rst_en: rsten_q, en: en_q};

    always_comb begin
        rdata_o = '0;
        case (addr)
            A_MODE:   rdata_o[MODE_W-1:0] = mode_rd;
            A_RELOAD: rdata_o[CNT_W-1:0]  = reload_q;
            A_VALUE:  rdata_o[CNT_W-1:0]  = value_q;
            default:  rdata_o = '0;
        endcase
    end

    AST_EN_STICKY: assert property (@(posedge pclk_i) disable iff (any_rst)
        en_q |=> en_q); // R8

    AST_RSTEN_STICKY: assert property (@(posedge pclk_i) disable iff (any_rst)
        rsten_q |=> rsten_q); // R8

    AST_FEED_AFTER_PREFIX: assert property (@(posedge pclk_i) disable iff (any_rst)
        !$stable(feed_tgl_o) |-> (($past(fstate) == F_ARMED) && $past(wr_en_i)
                                  && ($past(wdata_i) == KEY_CLOSE))); // R4

    AST_IRQ_ONLY_INT_MODE: assert property (@(posedge pclk_i) disable iff (any_rst)
        $rose(irq_o) |-> !$past(rsten_q)); // R7
endmodule

// File: rtl/wdt_dual_clock.sv
module wdt_dual_clock
    import wdt_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              pclk_i,
    input  logic              wclk_i,
    input  logic              rst_i,
    input  logic              por_i,
    input  logic [1:0]        addr_i,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              irq_o,
    output logic              rst_req_o
);
    wdt_cfg_t cfg;
    logic cfg_tgl, feed_tgl, to_tgl, snap_tgl, snap_ack;
    logic [CNT_W-1:0] snap_val;
    logic core_rst;

    assign core_rst = rst_i || por_i;

    wdt_bus_regs #(.SYNC_STAGES(SYNC_STAGES)) u_regs (
        .pclk_i     (pclk_i),
        .rst_i      (rst_i),
        .por_i      (por_i),
        .addr_i     (addr_i),
        .wr_en_i    (wr_en_i),
        .rd_en_i    (rd_en_i),
        .wdata_i    (wdata_i),
        .rdata_o    (rdata_o),
        .irq_o      (irq_o),
        .cfg_o      (cfg),
        .cfg_tgl_o  (cfg_tgl),
        .feed_tgl_o (feed_tgl),
        .to_tgl_i   (to_tgl),
        .snap_tgl_i (snap_tgl),
        .snap_val_i (snap_val),
        .snap_ack_o (snap_ack)
    );

    wdt_count_core #(.SYNC_STAGES(SYNC_STAGES)) u_core (
        .wclk_i     (wclk_i),
        .rst_i      (core_rst),
        .cfg_tgl_i  (cfg_tgl),
        .cfg_i      (cfg),
        .feed_tgl_i (feed_tgl),
        .snap_ack_i (snap_ack),
        .to_tgl_o   (to_tgl),
        .snap_tgl_o (snap_tgl),
        .snap_val_o (snap_val),
        .rst_req_o  (rst_req_o)
    );
endmodule

// File: tb/tb_wdt_dual_clock.sv
module tb_wdt_dual_clock;
    localparam int PCLK_PERIOD = 10;
    localparam int WCLK_PERIOD = 14;
    localparam int WDOG_CYC    = 150000;
    localparam logic [1:0] AD_MODE = 2'd0, AD_RELOAD = 2'd1, AD_FEED = 2'd2, AD_VALUE = 2'd3;

    logic pclk, wclk, rst_i, por_i, wr_en, rd_en, irq, rst_req;
    logic [1:0]  addr;
    logic [31:0] wdata, rdata;
    int nchk = 0, nerr = 0, wcnt = 0, base_wcnt = 0, last_wr_wcnt = 0;

    wdt_dual_clock dut (
        .pclk_i(pclk), .wclk_i(wclk), .rst_i(rst_i), .por_i(por_i),
        .addr_i(addr), .wr_en_i(wr_en), .rd_en_i(rd_en), .wdata_i(wdata),
        .rdata_o(rdata), .irq_o(irq), .rst_req_o(rst_req));

    initial begin
        pclk = 1'b0;
        forever #(PCLK_PERIOD/2) pclk = ~pclk;
    end

    // Watchdog clock edges fall on even times, bus edges on odd times
    initial begin
        wclk = 1'b0;
        #2;
        forever begin
            wclk = 1'b1; #(WCLK_PERIOD/2);
            wclk = 1'b0; #(WCLK_PERIOD/2);
        end
    end

    always @(posedge wclk) wcnt <= wcnt + 1;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic check_range(input string req, input int act, input int lo, input int hi);
        nchk++;
        if (act < lo || act > hi) begin
            nerr++;
            $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
        end
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge pclk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(posedge pclk);
        last_wr_wcnt = wcnt;
        @(negedge pclk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge pclk);
        addr = a; rd_en = 1'b1;
        #1 d = rdata;
        @(negedge pclk);
        rd_en = 1'b0;
    endtask

    task automatic feed();
        bus_wr(AD_FEED, 32'hAA);
        bus_wr(AD_FEED, 32'h55);
        base_wcnt = last_wr_wcnt;
    endtask

    task automatic do_reset(input logic full);
        @(negedge pclk);
        rst_i = 1'b1; por_i = full;
        repeat (5) @(negedge pclk);
        rst_i = 1'b0; por_i = 1'b0;
        repeat (2) @(negedge pclk);
    endtask

    task automatic wait_rst_req(input int limit, output int edges);
        int k;
        edges = -1; k = 0;
        while (k < limit && edges < 0) begin
            @(negedge wclk);
            if (rst_req) edges = wcnt - base_wcnt;
            k++;
        end
    endtask

    task automatic wait_irq(input int limit);
        int k;
        k = 0;
        while (k < limit && !irq) begin
            @(negedge pclk);
            k++;
        end
    endtask

    function automatic int sweep_val(input int i);
        case (i)
            0: return 0;      1: return 1;      2: return 'h7F;  3: return 'hFE;
            4: return 'hFF;   5: return 'h100;  6: return 'h101; default: return 'h103;
        endcase
    endfunction

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    endtask

    initial begin
        repeat (WDOG_CYC) @(posedge pclk);
        nerr++;
        $display("FAIL watchdog: actual hung run expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] rd, v1, v2;
        int edges, eff;
        rst_i = 1'b1; por_i = 1'b1; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
        do_reset(1'b1);

        // R12: reset state
        bus_rd(AD_MODE, rd);   check("R12 mode", rd, 32'h0);
        bus_rd(AD_RELOAD, rd); check("R12 reload", rd, 32'hFF);
        bus_rd(AD_VALUE, rd);  check("R12 value", rd, 32'h0);
        check("R12 irq", {31'd0, irq}, 32'd0);
        check("R12 rst_req", {31'd0, rst_req}, 32'd0);

        // R1/R2/R3 sweep of reload values across the clamp boundary
        for (int i = 0; i < 8; i++) begin
            do_reset(1'b1);
            bus_wr(AD_RELOAD, sweep_val(i));
            bus_rd(AD_RELOAD, rd); check("R3 raw readback", rd, sweep_val(i));
            bus_wr(AD_MODE, 32'h3);
            feed();
            eff = (sweep_val(i) < 'hFF) ? 'hFF : sweep_val(i);
            wait_rst_req(6000, edges);
            check(sweep_val(i) < 'hFF ? "R3 clamped interval" : "R1/R2 interval",
                  edges, 3 + 4*(eff + 1));
            repeat (50) @(negedge wclk);
            check("R6 rst_req held", {31'd0, rst_req}, 32'd1);
            bus_rd(AD_MODE, rd); check("R6 tof set", rd, 32'h7);
        end

        // R4: feed with enable clear does nothing
        do_reset(1'b1);
        bus_wr(AD_MODE, 32'h2);
        feed();
        repeat (1200) @(negedge wclk);
        check("R4 no start without enable", {31'd0, rst_req}, 32'd0);
        bus_rd(AD_VALUE, rd); check("R4 counter idle", rd, 32'h0);

        // R5: broken sequences
        do_reset(1'b1);
        bus_wr(AD_MODE, 32'h3);
        bus_wr(AD_FEED, 32'hAA); bus_rd(AD_MODE, rd); bus_wr(AD_FEED, 32'h55);
        bus_wr(AD_FEED, 32'hAA); bus_wr(AD_RELOAD, 32'hFF); bus_wr(AD_FEED, 32'h55);
        bus_wr(AD_FEED, 32'hAA); bus_wr(AD_FEED, 32'h56); bus_wr(AD_FEED, 32'h55);
        bus_wr(AD_FEED, 32'h55);
        repeat (1200) @(negedge wclk);
        check("R5 broken feed no start", {31'd0, rst_req}, 32'd0);
        bus_rd(AD_VALUE, rd); check("R5 counter idle", rd, 32'h0);
        bus_wr(AD_FEED, 32'hAA); bus_wr(AD_FEED, 32'hAA); bus_wr(AD_FEED, 32'h55);
        base_wcnt = last_wr_wcnt;
        wait_rst_req(6000, edges);
        check("R5 restart with 0xAA", edges, 3 + 4*256);

        // R4: refresh keeps the timer from expiring
        do_reset(1'b1);
        bus_wr(AD_RELOAD, 32'h100);
        bus_wr(AD_MODE, 32'h3);
        feed();
        for (int j = 0; j < 6; j++) begin
            repeat (600) @(negedge pclk);
            check("R4 refresh holds off", {31'd0, rst_req}, 32'd0);
            feed();
        end
        wait_rst_req(6000, edges);
        check("R4 interval after refresh", edges, 3 + 4*257);

        // R10: reload written right before the feed is the one loaded
        do_reset(1'b1);
        bus_wr(AD_MODE, 32'h3);
        bus_wr(AD_RELOAD, 32'h300);
        feed();
        wait_rst_req(8000, edges);
        check("R10 config before feed", edges, 3 + 4*('h300 + 1));

        // R7/R8/R9: interrupt mode
        do_reset(1'b1);
        bus_wr(AD_MODE, 32'h1);
        feed();
        wait_irq(2000);
        check("R7 irq raised", {31'd0, irq}, 32'd1);
        check("R7 no reset request", {31'd0, rst_req}, 32'd0);
        repeat (10) @(negedge pclk);
        bus_rd(AD_MODE, rd); check("R7 flags", rd, 32'hD);
        bus_wr(AD_MODE, 32'h0);
        bus_rd(AD_MODE, rd); check("R8 enable sticky", rd, 32'hD);
        bus_wr(AD_MODE, 32'hC);
        bus_rd(AD_MODE, rd); check("R9 write-one clears", rd, 32'h1);
        check("R9 irq cleared", {31'd0, irq}, 32'd0);
        wait_irq(1600);
        check("R7 keeps running", {31'd0, irq}, 32'd1);
        check("R7 still no reset request", {31'd0, rst_req}, 32'd0);
        bus_wr(AD_MODE, 32'h2);
        bus_wr(AD_MODE, 32'h0);
        bus_rd(AD_MODE, rd); check("R8 reset-mode sticky", rd & 32'h3, 32'h3);

        // R9: time-out flag across system and power-on reset
        do_reset(1'b1);
        bus_wr(AD_MODE, 32'h3);
        feed();
        wait_rst_req(6000, edges);
        repeat (10) @(negedge pclk);
        do_reset(1'b0);
        bus_rd(AD_MODE, rd); check("R9 tof survives rst", rd, 32'h4);
        check("R9 rst_req cleared", {31'd0, rst_req}, 32'd0);
        bus_wr(AD_MODE, 32'h4);
        bus_rd(AD_MODE, rd); check("R9 tof write-one clear", rd, 32'h0);
        bus_wr(AD_MODE, 32'h3);
        feed();
        wait_rst_req(6000, edges);
        repeat (10) @(negedge pclk);
        do_reset(1'b1);
        bus_rd(AD_MODE, rd); check("R9 por clears tof", rd, 32'h0);

        // R11: snapshot readback tracks the counter
        do_reset(1'b1);
        bus_wr(AD_RELOAD, 32'h1000);
        bus_wr(AD_MODE, 32'h1);
        feed();
        repeat (100) @(negedge pclk);
        bus_rd(AD_VALUE, v1);
        repeat (400) @(negedge pclk);
        bus_rd(AD_VALUE, v2);
        check_range("R11 first snapshot", int'(v1), 'h1000 - 30, 'h1000);
        check_range("R11 decrease", int'(v1) - int'(v2), 66, 78);

        summary();
        $finish;
    end
endmodule